// File: doc/BRIEF.md
# Fetch Next-PC Predictor with Redirect

This block is the fetch front end of a two-stage pipeline. It holds the fetch program counter. Every cycle it looks that address up in a small direct-mapped target buffer and offers a predicted next fetch address. On a hit the stored target is used. On a miss the sequential address, fetch PC plus 4, is used. Unless something overrides it, the predicted address becomes the fetch PC on the next clock.

The execute stage is modelled by a single resolution port. It carries the resolved instruction's address, its true successor, a taken flag, a control-instruction flag, a mispredict flag and the one-bit epoch the instruction was fetched under. A live resolution is one whose epoch matches the block's current epoch. A live control instruction trains the buffer: a taken outcome writes the entry, and a not-taken outcome erases the entry only when that entry belongs to the same address. A live mispredict steers fetch to the true successor and flips the epoch. Everything already fetched under the old epoch then arrives at execute as dead and is dropped.

Top module: `fetch_nextpc_unit`

## Requirements
- R1: After reset the fetch PC equals parameter RESET_PC, the epoch is 0 and every buffer entry is invalid, so the prediction is fetch PC + 4.
- R2: The entry for address A is selected by A[IDX_W+1:2], and its tag is A[PC_W-1:IDX_W+2]. A lookup hits only when the selected entry is valid and its tag equals the tag of A. A different address that selects the same entry misses.
- R3: `pred_pc` is the stored target on a hit and fetch_pc + 4 on a miss.
- R4: A live resolution with ex_ctrl=1 and ex_taken=1 marks the entry of ex_pc valid and stores its tag and ex_next_pc as the target. A later lookup of that address hits and returns that target.
- R5: A live resolution with ex_ctrl=1 and ex_taken=0 invalidates the selected entry only when the entry's tag matches ex_pc. When the tag differs, the entry and its target are kept.
- R6: A resolution with ex_ctrl=0 never changes the buffer, whatever ex_taken says.
- R7: A live resolution with ex_mispred=1 makes fetch_pc equal ex_next_pc on the next clock and inverts fetch_epoch.
- R8: `ex_live` is ex_valid AND (ex_epoch == fetch_epoch). A resolution that is not live neither trains the buffer nor redirects fetch.
- R9: Without a live mispredict, fetch_pc takes the value of pred_pc on the next clock and the epoch is unchanged.
- R10: When a redirect and a lookup occur in the same cycle, the redirect address wins as the next fetch PC. The lookup in that cycle uses the buffer contents from before that cycle's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ex_valid | input | 1 | A resolved instruction is presented |
| ex_epoch | input | 1 | Epoch under which that instruction was fetched |
| ex_pc | input | PC_W | Address of the resolved instruction |
| ex_next_pc | input | PC_W | True successor address |
| ex_taken | input | 1 | Control transfer was taken |
| ex_ctrl | input | 1 | Instruction is a branch or jump |
| ex_mispred | input | 1 | Fetch followed the wrong successor |
| fetch_pc | output | PC_W | Current fetch address |
| fetch_epoch | output | 1 | Epoch attached to the current fetch |
| pred_pc | output | PC_W | Predicted next fetch address |
| ex_live | output | 1 | Resolution belongs to the current epoch |

## Verification
The hardest situation to reach is a hit. The fetch PC is internal state, so a lookup only hits when fetch happens to land on an address that was trained earlier. The stimulus creates these lookups on purpose. It first trains an entry, then issues a mispredict redirect whose true successor is that same address. On the next cycle the lookup runs against the freshly written entry, or against an aliasing neighbour that shares its index. A long random phase then draws resolution addresses and targets from a small pool of aliasing addresses. This keeps fetch bouncing between trained entries, and stale-epoch resolutions are mixed in.

// File: rtl/nxtpc_pkg.sv
package nxtpc_pkg;

   // Which next-address predictor a build uses.
   typedef enum logic {
      PK_SEQ  = 1'b0,   // sequential only, no storage
      PK_TBUF = 1'b1    // direct-mapped target buffer
   } pred_kind_e;

   // Instructions are 4 bytes; the two low address bits carry no information.
   localparam int unsigned BYTE_OFS_W = 2;
   localparam int unsigned INSN_BYTES = 4;

endpackage

// File: rtl/nxtpc_tbuf.sv
module nxtpc_tbuf #(
   parameter int unsigned PC_W  = 32,
   parameter int unsigned IDX_W = 4
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic [PC_W-1:nxtpc_pkg::BYTE_OFS_W]      look_word,
   output logic                                     look_hit,
   output logic [PC_W-1:0]                          look_tgt,
   input  logic                                     upd_en,
   input  logic                                     upd_taken,
   input  logic [PC_W-1:nxtpc_pkg::BYTE_OFS_W]      upd_word,
   input  logic [PC_W-1:0]                          upd_tgt
);
   import nxtpc_pkg::*;

   localparam int unsigned ENTRIES = 1 << IDX_W;
   localparam int unsigned TAG_LO  = BYTE_OFS_W + IDX_W;
   localparam int unsigned TAG_W   = PC_W - TAG_LO;

   if (TAG_W < 1) begin : g_bad_geom
      $error("nxtpc_tbuf: PC_W too small for IDX_W");
   end

   logic [ENTRIES-1:0] vld_q;
   logic [TAG_W-1:0]   tag_q [ENTRIES];
   logic [PC_W-1:0]    tgt_q [ENTRIES];

   logic [IDX_W-1:0]   look_idx, upd_idx;
   logic [TAG_W-1:0]   look_tag, upd_tag;
   logic               upd_owner;

   assign look_idx  = look_word[TAG_LO-1:BYTE_OFS_W];
   assign look_tag  = look_word[PC_W-1:TAG_LO];
   assign upd_idx   = upd_word[TAG_LO-1:BYTE_OFS_W];
   assign upd_tag   = upd_word[PC_W-1:TAG_LO];
   assign upd_owner = vld_q[upd_idx] && (tag_q[upd_idx] == upd_tag);

   // Combinational lookup reads the state held before this cycle's write.
   assign look_hit = vld_q[look_idx] && (tag_q[look_idx] == look_tag);
   assign look_tgt = tgt_q[look_idx];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      logic sel;
      assign sel = upd_en && (upd_idx == IDX_W'(e));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            vld_q[e] <= 1'b0;
         end else if (sel) begin
            if (upd_taken) begin
               vld_q[e] <= 1'b1;
            end else if (upd_owner) begin
               vld_q[e] <= 1'b0;
            end
         end
      end

      always_ff @(posedge clk) begin
         if (sel && upd_taken) begin
            tag_q[e] <= upd_tag;
            tgt_q[e] <= upd_tgt;
         end
      end
   end

   AST_ALLOC_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && upd_taken) |=>
         (look_word != $past(upd_word)) || (look_hit && look_tgt == $past(upd_tgt))); // R4

   AST_OWNER_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !upd_taken && upd_owner) |=>
         (look_word != $past(upd_word)) || !look_hit); // R5

   AST_ALIEN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_en && !upd_taken && !upd_owner) |=> (vld_q == $past(vld_q))); // R5

   AST_QUIET_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      !upd_en |=> (vld_q == $past(vld_q))); // R6

endmodule

// File: rtl/nxtpc_predict.sv
module nxtpc_predict #(
   parameter int unsigned           PC_W  = 32,
   parameter int unsigned           IDX_W = 4,
   parameter nxtpc_pkg::pred_kind_e KIND  = nxtpc_pkg::PK_TBUF
) (
   input  logic                                     clk,
   input  logic                                     rst_n,
   input  logic [PC_W-1:0]                          look_pc,
   output logic [PC_W-1:0]                          pred_pc,
   input  logic                                     upd_en,
   input  logic                                     upd_taken,
   input  logic [PC_W-1:0]                          upd_pc,
   input  logic [PC_W-1:0]                          upd_tgt
);
   import nxtpc_pkg::*;

   logic [PC_W-1:0] seq_pc;
   assign seq_pc = look_pc + PC_W'(INSN_BYTES);

   if (KIND == PK_TBUF) begin : g_tbuf
      logic            hit;
      logic [PC_W-1:0] tgt;

      nxtpc_tbuf #(
         .PC_W  (PC_W),
         .IDX_W (IDX_W)
      ) i_tbuf (
         .clk       (clk),
         .rst_n     (rst_n),
         .look_word (look_pc[PC_W-1:BYTE_OFS_W]),
         .look_hit  (hit),
         .look_tgt  (tgt),
         .upd_en    (upd_en),
         .upd_taken (upd_taken),
         .upd_word  (upd_pc[PC_W-1:BYTE_OFS_W]),
         .upd_tgt   (upd_tgt)
      );

      assign pred_pc = hit ? tgt : seq_pc;

      AST_MISS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
         !hit |-> (pred_pc - look_pc) == PC_W'(INSN_BYTES)); // R3
   end else begin : g_seq
      assign pred_pc = seq_pc;
   end

endmodule

// File: rtl/nxtpc_steer.sv
module nxtpc_steer #(
   parameter int unsigned     PC_W     = 32,
   parameter logic [PC_W-1:0] RESET_PC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [PC_W-1:0] pred_pc,
   input  logic            redir,
   input  logic [PC_W-1:0] redir_pc,
   output logic [PC_W-1:0] fetch_pc,
   output logic            epoch
);

   logic [PC_W-1:0] pc_q, pc_d;
   logic            ep_q;

   // The redirect address overrides the prediction made in the same cycle.
   assign pc_d = redir ? redir_pc : pred_pc;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_q <= RESET_PC;
         ep_q <= 1'b0;
      end else begin
         pc_q <= pc_d;
         ep_q <= ep_q ^ redir;
      end
   end

   assign fetch_pc = pc_q;
   assign epoch    = ep_q;

   AST_REDIRECT_STEER: assert property (@(posedge clk) disable iff (!rst_n)
      redir |=> (fetch_pc == $past(redir_pc)) && (epoch != $past(epoch))); // R7

   AST_FOLLOW_PRED: assert property (@(posedge clk) disable iff (!rst_n)
      !redir |=> (fetch_pc == $past(pred_pc)) && $stable(epoch)); // R9

endmodule

// File: rtl/fetch_nextpc_unit.sv
module fetch_nextpc_unit #(
   parameter int unsigned           PC_W     = 32,
   parameter int unsigned           IDX_W    = 4,
   parameter logic [PC_W-1:0]       RESET_PC = '0,
   parameter nxtpc_pkg::pred_kind_e KIND     = nxtpc_pkg::PK_TBUF
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ex_valid,
   input  logic            ex_epoch,
   input  logic [PC_W-1:0] ex_pc,
   input  logic [PC_W-1:0] ex_next_pc,
   input  logic            ex_taken,
   input  logic            ex_ctrl,
   input  logic            ex_mispred,
   output logic [PC_W-1:0] fetch_pc,
   output logic            fetch_epoch,
   output logic [PC_W-1:0] pred_pc,
   output logic            ex_live
);
   import nxtpc_pkg::*;

   if (IDX_W < 1 || PC_W < IDX_W + BYTE_OFS_W + 1) begin : g_bad_width
      $error("fetch_nextpc_unit: inconsistent PC_W / IDX_W");
   end
   if (RESET_PC[BYTE_OFS_W-1:0] != '0) begin : g_bad_reset_pc
      $error("fetch_nextpc_unit: RESET_PC must be instruction aligned");
   end

   logic train, redir;

   // Resolutions from a flushed epoch are dropped entirely.
   assign ex_live = ex_valid && (ex_epoch == fetch_epoch);
   assign train   = ex_live && ex_ctrl;
   assign redir   = ex_live && ex_mispred;

   nxtpc_predict #(
      .PC_W  (PC_W),
      .IDX_W (IDX_W),
      .KIND  (KIND)
   ) i_predict (
      .clk       (clk),
      .rst_n     (rst_n),
      .look_pc   (fetch_pc),
      .pred_pc   (pred_pc),
      .upd_en    (train),
      .upd_taken (ex_taken),
      .upd_pc    (ex_pc),
      .upd_tgt   (ex_next_pc)
   );

   nxtpc_steer #(
      .PC_W     (PC_W),
      .RESET_PC (RESET_PC)
   ) i_steer (
      .clk      (clk),
      .rst_n    (rst_n),
      .pred_pc  (pred_pc),
      .redir    (redir),
      .redir_pc (ex_next_pc),
      .fetch_pc (fetch_pc),
      .epoch    (fetch_epoch)
   );

   AST_STALE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_valid && !ex_live) |=> $stable(fetch_epoch)); // R8

   AST_REDIRECT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (ex_live && ex_mispred) |=> (fetch_pc == $past(ex_next_pc))); // R10

endmodule

// File: tb/test_fetch_nextpc_unit.sv
`timescale 1ns/1ps
module test_fetch_nextpc_unit;

   localparam int PC_W = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            ex_valid = 1'b0, ex_epoch = 1'b0, ex_taken = 1'b0;
   logic            ex_ctrl = 1'b0, ex_mispred = 1'b0;
   logic [PC_W-1:0] ex_pc = '0, ex_next_pc = '0;
   logic [PC_W-1:0] fetch_pc, pred_pc;
   logic            fetch_epoch, ex_live;

   always #2.5 clk = ~clk;

   fetch_nextpc_unit #(.PC_W(PC_W), .IDX_W(4), .RESET_PC('0)) i_fetch_nextpc_unit (
      .clk, .rst_n, .ex_valid, .ex_epoch, .ex_pc, .ex_next_pc, .ex_taken,
      .ex_ctrl, .ex_mispred, .fetch_pc, .fetch_epoch, .pred_pc, .ex_live);

   // Behavioural reference: owner address and target per slot, keyed by slot.
   bit              m_valid [int];
   logic [PC_W-1:0] m_owner [int];
   logic [PC_W-1:0] m_tgt   [int];
   logic [PC_W-1:0] m_pc = '0;
   logic            m_ep = 1'b0;
   int              n_cmp = 0, n_bad = 0;

   function automatic int slot_of(logic [PC_W-1:0] a);
      return int'((a / 4) % 16);
   endfunction

   function automatic logic [PC_W-1:0] model_pred(logic [PC_W-1:0] a);
      int s = slot_of(a);
      if (m_valid.exists(s) && m_valid[s] && (m_owner[s] / 64) == (a / 64))
         return m_tgt[s];
      return a + 4;
   endfunction

   task automatic cmp(string req, string what, logic [PC_W-1:0] act, logic [PC_W-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s actual %h expected %h at %0t", req, what, act, exp, $time);
      end
   endtask

   // One clock: inputs already driven at the falling edge; compare, then advance model.
   task automatic step(string ptag);
      logic [PC_W-1:0] exp_pred;
      logic            live;
      int              s;
      #1;
      exp_pred = model_pred(m_pc);
      live     = ex_valid && (ex_epoch == m_ep);
      cmp(ptag, "pred_pc", pred_pc, exp_pred);           // R3
      cmp("R8", "ex_live", ex_live, live);
      cmp("R7", "fetch_epoch", fetch_epoch, m_ep);
      @(posedge clk);
      if (live && ex_ctrl) begin
         s = slot_of(ex_pc);
         if (ex_taken) begin
            m_valid[s] = 1'b1; m_owner[s] = ex_pc; m_tgt[s] = ex_next_pc;
         end else if (m_valid.exists(s) && (m_owner[s] / 64) == (ex_pc / 64)) begin
            m_valid[s] = 1'b0;
         end
      end
      if (live && ex_mispred) begin
         m_pc = ex_next_pc; m_ep = ~m_ep;          // R7, R10
      end else begin
         m_pc = exp_pred;                          // R9
      end
      @(negedge clk);
      cmp(live && ex_mispred ? "R7" : "R9", "fetch_pc", fetch_pc, m_pc);
   endtask

   task automatic exe(logic [PC_W-1:0] a, logic [PC_W-1:0] n, bit tk, bit ct, bit mp, string tg);
      ex_valid = 1; ex_epoch = m_ep; ex_pc = a; ex_next_pc = n;
      ex_taken = tk; ex_ctrl = ct; ex_mispred = mp;
      step(tg);
   endtask

   task automatic idle(string tg);
      ex_valid = 0; ex_taken = 0; ex_ctrl = 0; ex_mispred = 0;
      step(tg);
   endtask

   initial begin : watchdog
      #(5ns * 150000);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      logic [PC_W-1:0] pool [8];
      pool = '{32'h000, 32'h040, 32'h100, 32'h104, 32'h140, 32'h1000, 32'h1040, 32'h03c};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      cmp("R1", "fetch_pc", fetch_pc, 32'h0);
      cmp("R1", "fetch_epoch", fetch_epoch, 1'b0);
      idle("R1");
      // R6: non-control redirect to 0x240 must not allocate
      exe(32'h000, 32'h240, 1, 0, 1, "R1");
      // R10: lookup of 0x240 in the same cycle it is trained sees old contents (R6: still miss)
      exe(32'h240, 32'h300, 1, 1, 0, "R10");
      exe(32'h010, 32'h240, 0, 0, 1, "R9");
      idle("R4");                                  // fetch 0x240 hits -> 0x300
      // R5: not-taken for alias 0x200 (same slot, other tag) keeps the entry
      exe(32'h200, 32'h240, 0, 1, 1, "R9");
      idle("R5");                                  // still hits -> 0x300
      // R2: alias address 0x200 misses although its slot is valid
      exe(32'h004, 32'h200, 0, 0, 1, "R9");
      idle("R2");
      // R5: not-taken from the owner clears; fetch 0x240 then misses
      exe(32'h240, 32'h240, 0, 1, 1, "R9");
      idle("R5");
      // R8: stale resolution neither redirects nor trains
      ex_valid = 1; ex_epoch = ~m_ep; ex_pc = 32'h244; ex_next_pc = 32'h500;
      ex_taken = 1; ex_ctrl = 1; ex_mispred = 1;
      step("R8");
      exe(32'h000, 32'h244, 0, 0, 1, "R8");
      idle("R8");                                  // 0x244 must miss
      // Random phase over aliasing pool
      for (int i = 0; i < 4000; i++) begin
         ex_valid   = ($urandom % 4) != 0;
         ex_epoch   = (($urandom % 8) == 0) ? ~m_ep : m_ep;
         ex_pc      = pool[$urandom % 8];
         ex_next_pc = pool[$urandom % 8];
         ex_taken   = $urandom % 2;
         ex_ctrl    = ($urandom % 4) != 0;
         ex_mispred = ($urandom % 4) == 0;
         step("R3");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule